// File: doc/BRIEF.md
# Protected Register Write Sequencer

This block keeps a small bank of protected clock/control registers safe from stray writes. It sits behind a 2-wire serial target front end. That front end decodes the bus into single-cycle events: a start condition, a stop condition, a received byte with its value, and a flag for a malformed transfer. Software must first write two volatile enable latches held in a status location. Only then will a framed burst of data bytes reach the protected bank.

Each step is its own transaction, from a start condition to a stop condition. The select byte `DEh` opens a write, and the next byte is an address. If the address is the status location (`3Fh` by default), one data byte follows. If the address falls inside the bank, one to eight data bytes follow, and the address advances by one after each byte. Burst bytes are held in a staging buffer. They are copied into the bank only when a clean stop condition arrives.

A successful copy starts a commit countdown that models the slow nonvolatile write. While the countdown runs, the busy flag is high. When it finishes, the second enable latch clears, so the whole sequence must be repeated before the next change.

Top module: `ccr_write_guard`

## Requirements
- R1: After reset, both enable latches read 0, busy reads 0 and every bank byte reads 00h.
- R2: A status write of 02h (select DEh, address 3Fh, one data byte, stop) sets the write latch and clears the register latch. It takes effect at the stop, with no busy period.
- R3: A status write of 06h sets both latches, but only if the write latch is already set; otherwise it changes nothing. The register latch is never set while the write latch is clear.
- R4: A status write of 00h clears both latches. Any data value other than 00h, 02h or 06h leaves both latches unchanged.
- R5: With both latches set and busy low, a burst (select DEh, start address below NREG, 1 to BURST data bytes, stop) writes byte k to address start+k. The bank changes only in the cycle after that stop.
- R6: A burst issued while either latch is clear leaves the bank unchanged and does not raise busy.
- R7: A commit holds busy high for exactly COMMIT_CYCLES cycles. When busy falls, the register latch clears and the write latch is kept, so a further burst is ignored until 06h is written again.
- R8: A burst aborted by a new start condition before its stop, by the malformed flag, or by more than BURST data bytes is not committed, raises no busy, and leaves both latches unchanged.
- R9: A burst whose start address is at or above NREG (and is not 3Fh) has no effect and raises no busy. Bytes whose advanced address passes NREG-1 are dropped, and the rest of the burst is committed.
- R10: Transactions with select DFh (read) or any select byte other than DEh change neither the latches nor the bank.
- R11: A burst arriving while busy is high is rejected: the bank is unchanged and the countdown is not restarted.
- R12: A status write carrying more than one data byte is discarded and leaves the latches unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start condition seen (one-cycle pulse) |
| stop_i | input | 1 | Stop condition seen (one-cycle pulse) |
| byte_i | input | 1 | A byte was received (one-cycle pulse) |
| bad_i | input | 1 | The current transfer is malformed (one-cycle pulse) |
| data_i | input | 8 | Value of the received byte, valid with byte_i |
| regs_o | output | NREG*8 | Protected bank; byte k at bits 8k+7:8k |
| busy_o | output | 1 | Commit countdown running |
| wel_o | output | 1 | Write enable latch |
| rwel_o | output | 1 | Register write enable latch |

## Verification
The bound checker tests these rules on every cycle:
- the register latch never stands without the write latch;
- the bank moves only in the cycle after a stop, and only as busy rises;
- busy rises only when both latches were set;
- the register latch is clear when busy falls.

Other behaviours need the bench's scenarios. These are the value decoding of status writes, address auto-increment and dropping past the bank end, the three kinds of abort, the exact countdown length, and that a burst sent during busy does not restart the countdown.

// File: rtl/wgd_pkg.sv
package wgd_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SEL,
        PH_ADDR,
        PH_DATA,
        PH_SKIP
    } phase_e;

    typedef enum logic {
        TGT_STAT,
        TGT_PROT
    } target_e;

    localparam logic [7:0] SEL_WRITE = 8'hDE;
    localparam logic [7:0] CMD_CLEAR = 8'h00;
    localparam logic [7:0] CMD_WEL   = 8'h02;
    localparam logic [7:0] CMD_BOTH  = 8'h06;

endpackage

// File: rtl/wgd_frame.sv
module wgd_frame
    import wgd_pkg::*;
#(
    parameter int NREG        = 8,
    parameter int BURST       = 8,
    parameter logic [7:0] STATUS_ADDR = 8'h3F,
    localparam int IDXW = (BURST > 1) ? $clog2(BURST) : 1,
    localparam int CNTW = $clog2(BURST + 1)
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            start_i,
    input  logic            stop_i,
    input  logic            byte_i,
    input  logic            bad_i,
    input  logic [7:0]      data_i,
    output logic            stg_we_o,
    output logic [IDXW-1:0] stg_idx_o,
    output logic            stat_go_o,
    output logic [7:0]      stat_val_o,
    output logic            prot_go_o,
    output logic [7:0]      prot_base_o,
    output logic [CNTW-1:0] prot_cnt_o
);

    localparam logic [8:0]      NREG_W  = 9'(NREG);
    localparam logic [CNTW-1:0] BURST_C = CNTW'(BURST);
    localparam logic [CNTW-1:0] ONE_C   = CNTW'(1);

    typedef struct packed {
        phase_e          phase;
        target_e         tgt;
        logic [7:0]      base;
        logic [CNTW-1:0] cnt;
        logic [7:0]      sval;
    } frame_t;

    frame_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        stg_we_o  = 1'b0;
        stat_go_o = 1'b0;
        prot_go_o = 1'b0;
        if (start_i) begin
            s_d.phase = PH_SEL;
            s_d.cnt   = '0;
        end else if (stop_i) begin
            if (s_q.phase == PH_DATA) begin
                if (s_q.tgt == TGT_STAT) begin
                    stat_go_o = (s_q.cnt == ONE_C);
                end else begin
                    prot_go_o = (s_q.cnt != '0);
                end
            end
            s_d.phase = PH_IDLE;
        end else if (bad_i) begin
            if (s_q.phase != PH_IDLE) begin
                s_d.phase = PH_SKIP;
            end
        end else if (byte_i) begin
            case (s_q.phase)
                PH_SEL: begin
                    s_d.phase = (data_i == SEL_WRITE) ? PH_ADDR : PH_SKIP;
                end
                PH_ADDR: begin
                    if (data_i == STATUS_ADDR) begin
                        s_d.tgt   = TGT_STAT;
                        s_d.phase = PH_DATA;
                    end else if ({1'b0, data_i} < NREG_W) begin
                        s_d.tgt   = TGT_PROT;
                        s_d.base  = data_i;
                        s_d.phase = PH_DATA;
                    end else begin
                        s_d.phase = PH_SKIP;
                    end
                end
                PH_DATA: begin
                    if (s_q.tgt == TGT_STAT) begin
                        if (s_q.cnt == '0) begin
                            s_d.sval = data_i;
                            s_d.cnt  = ONE_C;
                        end else begin
                            s_d.phase = PH_SKIP;
                        end
                    end else begin
                        if (s_q.cnt == BURST_C) begin
                            s_d.phase = PH_SKIP;
                        end else begin
                            stg_we_o = 1'b1;
                            s_d.cnt  = s_q.cnt + ONE_C;
                        end
                    end
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q <= '{phase: PH_IDLE, tgt: TGT_STAT, base: '0, cnt: '0, sval: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign stg_idx_o   = IDXW'(s_q.cnt);
    assign stat_val_o  = s_q.sval;
    assign prot_base_o = s_q.base;
    assign prot_cnt_o  = s_q.cnt;

endmodule

// File: rtl/wgd_stage.sv
module wgd_stage #(
    parameter int BURST = 8,
    localparam int IDXW = (BURST > 1) ? $clog2(BURST) : 1
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 we_i,
    input  logic [IDXW-1:0]      idx_i,
    input  logic [7:0]           data_i,
    output logic [BURST*8-1:0]   stage_o
);

    typedef struct packed {
        logic [BURST-1:0][7:0] mem;
    } stage_t;

    stage_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (we_i) begin
            s_d.mem[idx_i] = data_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign stage_o = s_q.mem;

endmodule

// File: rtl/wgd_timer.sv
module wgd_timer #(
    parameter int COMMIT_CYCLES = 1250000,
    localparam int TW = (COMMIT_CYCLES > 1) ? $clog2(COMMIT_CYCLES) : 1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    output logic busy_o,
    output logic done_o
);

    localparam logic [TW-1:0] LOAD = TW'(COMMIT_CYCLES - 1);

    typedef struct packed {
        logic          busy;
        logic [TW-1:0] cnt;
    } timer_t;

    timer_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        done_o = 1'b0;
        if (s_q.busy) begin
            if (s_q.cnt == '0) begin
                s_d.busy = 1'b0;
                done_o   = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt - TW'(1);
            end
        end else if (start_i) begin
            s_d.busy = 1'b1;
            s_d.cnt  = LOAD;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o = s_q.busy;

endmodule

// File: rtl/ccr_write_guard.sv
module ccr_write_guard
    import wgd_pkg::*;
#(
    parameter int NREG          = 8,
    parameter int BURST         = 8,
    parameter int COMMIT_CYCLES = 1250000,
    parameter logic [7:0] STATUS_ADDR = 8'h3F
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                start_i,
    input  logic                stop_i,
    input  logic                byte_i,
    input  logic                bad_i,
    input  logic [7:0]          data_i,
    output logic [NREG*8-1:0]   regs_o,
    output logic                busy_o,
    output logic                wel_o,
    output logic                rwel_o
);

    localparam int IDXW = (BURST > 1) ? $clog2(BURST) : 1;
    localparam int CNTW = $clog2(BURST + 1);
    localparam int AW   = (NREG > 1) ? $clog2(NREG) : 1;
    localparam logic [8:0] NREG_W = 9'(NREG);

    typedef struct packed {
        logic                 wel;
        logic                 rwel;
        logic [NREG-1:0][7:0] bank;
    } guard_t;

    guard_t s_d, s_q;

    logic            stg_we;
    logic [IDXW-1:0] stg_idx;
    logic            stat_go;
    logic [7:0]      stat_val;
    logic            prot_go;
    logic [7:0]      prot_base;
    logic [CNTW-1:0] prot_cnt;
    logic [BURST*8-1:0] stage;
    logic            tmr_busy;
    logic            tmr_done;
    logic            commit_go;

    wgd_frame #(
        .NREG        (NREG),
        .BURST       (BURST),
        .STATUS_ADDR (STATUS_ADDR)
    ) u_frame (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .start_i     (start_i),
        .stop_i      (stop_i),
        .byte_i      (byte_i),
        .bad_i       (bad_i),
        .data_i      (data_i),
        .stg_we_o    (stg_we),
        .stg_idx_o   (stg_idx),
        .stat_go_o   (stat_go),
        .stat_val_o  (stat_val),
        .prot_go_o   (prot_go),
        .prot_base_o (prot_base),
        .prot_cnt_o  (prot_cnt)
    );

    wgd_stage #(
        .BURST (BURST)
    ) u_stage (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (stg_we),
        .idx_i   (stg_idx),
        .data_i  (data_i),
        .stage_o (stage)
    );

    wgd_timer #(
        .COMMIT_CYCLES (COMMIT_CYCLES)
    ) u_timer (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (commit_go),
        .busy_o  (tmr_busy),
        .done_o  (tmr_done)
    );

    always_comb begin
        logic [8:0] addr;
        s_d       = s_q;
        addr      = '0;
        commit_go = 1'b0;

        if (tmr_done) begin
            s_d.rwel = 1'b0;
        end

        if (stat_go) begin
            case (stat_val)
                CMD_CLEAR: begin
                    s_d.wel  = 1'b0;
                    s_d.rwel = 1'b0;
                end
                CMD_WEL: begin
                    s_d.wel  = 1'b1;
                    s_d.rwel = 1'b0;
                end
                CMD_BOTH: begin
                    if (s_q.wel) begin
                        s_d.wel  = 1'b1;
                        s_d.rwel = 1'b1;
                    end
                end
                default: begin
                end
            endcase
        end

        if (prot_go && s_q.wel && s_q.rwel && !tmr_busy) begin
            commit_go = 1'b1;
            for (int i = 0; i < BURST; i++) begin
                addr = {1'b0, prot_base} + 9'(i);
                if ((CNTW'(i) < prot_cnt) && (addr < NREG_W)) begin
                    s_d.bank[AW'(addr)] = stage[i*8 +: 8];
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign regs_o = s_q.bank;
    assign busy_o = tmr_busy;
    assign wel_o  = s_q.wel;
    assign rwel_o = s_q.rwel;

endmodule

// File: rtl/wgd_checker.sv
module wgd_checker #(
    parameter int NREG = 8
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              stop_i,
    input logic [NREG*8-1:0] regs_o,
    input logic              busy_o,
    input logic              wel_o,
    input logic              rwel_o
);

    AST_RWEL_NEEDS_WEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rwel_o |-> wel_o); // R3

    AST_BANK_AFTER_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(regs_o) |-> $past(stop_i)); // R5

    AST_BANK_WITH_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(regs_o) |-> $rose(busy_o)); // R11

    AST_BUSY_NEEDS_LATCHES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_o) |-> $past(wel_o && rwel_o)); // R6

    AST_RWEL_CLEARED_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($fell(busy_o) && !$past(stop_i)) |-> !rwel_o); // R7

endmodule

bind ccr_write_guard wgd_checker #(.NREG(NREG)) u_wgd_checker (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .stop_i (stop_i),
    .regs_o (regs_o),
    .busy_o (busy_o),
    .wel_o  (wel_o),
    .rwel_o (rwel_o)
);

// File: tb/tb_ccr_write_guard.sv
module tb_ccr_write_guard;

    localparam int NREG  = 8;
    localparam int BURST = 8;
    localparam int CCYC  = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, stop = 1'b0, bytev = 1'b0, bad = 1'b0;
    logic [7:0] data = '0;
    logic [NREG*8-1:0] regs;
    logic busy, wel, rwel;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic [NREG*8-1:0] mdl = '0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ccr_write_guard #(
        .NREG (NREG), .BURST (BURST), .COMMIT_CYCLES (CCYC), .STATUS_ADDR (8'h3F)
    ) dut (
        .clk_i (clk), .rst_ni (rst_n), .start_i (start), .stop_i (stop),
        .byte_i (bytev), .bad_i (bad), .data_i (data),
        .regs_o (regs), .busy_o (busy), .wel_o (wel), .rwel_o (rwel)
    );

    // {data, expected wel, expected rwel} for successive status writes
    localparam logic [9:0] VEC [0:11] = '{
        {8'h00, 1'b0, 1'b0}, {8'h06, 1'b0, 1'b0}, {8'h55, 1'b0, 1'b0},
        {8'h02, 1'b1, 1'b0}, {8'h55, 1'b1, 1'b0}, {8'h06, 1'b1, 1'b1},
        {8'h04, 1'b1, 1'b1}, {8'h02, 1'b1, 1'b0}, {8'h06, 1'b1, 1'b1},
        {8'h00, 1'b0, 1'b0}, {8'h04, 1'b0, 1'b0}, {8'h06, 1'b0, 1'b0}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // kind: 0 start, 1 stop, 2 byte, 3 malformed
    task automatic ev(input int kind, input logic [7:0] d);
        start = (kind == 0);
        stop  = (kind == 1);
        bytev = (kind == 2);
        bad   = (kind == 3);
        data  = d;
        @(negedge clk);
        start = 1'b0; stop = 1'b0; bytev = 1'b0; bad = 1'b0;
    endtask

    task automatic stat_write(input logic [7:0] v);
        ev(0, 0); ev(2, 8'hDE); ev(2, 8'h3F); ev(2, v); ev(1, 0);
    endtask

    task automatic burst(input logic [7:0] addr, input int n, input logic [7:0] seed);
        ev(0, 0); ev(2, 8'hDE); ev(2, addr);
        for (int i = 0; i < n; i++) ev(2, seed + 8'(i));
        ev(1, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int t0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 latches", {62'b0, wel, rwel}, 64'd0);
        chk("R1 busy", {63'b0, busy}, 64'd0);
        chk("R1 bank", regs, 64'd0);

        // R2 R3 R4 status write decoding
        for (int k = 0; k < 12; k++) begin
            stat_write(VEC[k][9:2]);
            chk("R2_R3_R4 latches", {62'b0, wel, rwel}, {62'b0, VEC[k][1:0]});
            chk("R2 no busy", {63'b0, busy}, 64'd0);
        end

        // R6 burst with latches clear
        burst(8'h02, 2, 8'h10);
        chk("R6 bank", regs, mdl);
        chk("R6 busy", {63'b0, busy}, 64'd0);

        // R5 R7 valid commit
        stat_write(8'h02); stat_write(8'h06);
        burst(8'h01, 3, 8'hA1);
        t0 = cyc;
        mdl[8 +: 8] = 8'hA1; mdl[16 +: 8] = 8'hA2; mdl[24 +: 8] = 8'hA3;
        chk("R5 bank", regs, mdl);
        chk("R7 busy up", {63'b0, busy}, 64'd1);
        while (busy) @(negedge clk);
        chk("R7 length", 64'(cyc - t0), 64'(CCYC));
        chk("R7 latches after", {62'b0, wel, rwel}, 64'b10);
        burst(8'h00, 1, 8'h33);
        chk("R7 repeat needed", regs, mdl);
        chk("R7 no busy", {63'b0, busy}, 64'd0);

        // R8 aborts
        stat_write(8'h06);
        ev(0, 0); ev(2, 8'hDE); ev(2, 8'h00); ev(2, 8'h44); ev(0, 0); ev(1, 0);
        chk("R8 restart bank", regs, mdl);
        chk("R8 restart latches", {62'b0, wel, rwel}, 64'b11);
        ev(0, 0); ev(2, 8'hDE); ev(2, 8'h00); ev(2, 8'h45); ev(3, 0); ev(1, 0);
        chk("R8 malformed bank", regs, mdl);
        burst(8'h00, 9, 8'h50);
        chk("R8 overlong bank", regs, mdl);
        chk("R8 busy", {63'b0, busy}, 64'd0);
        chk("R8 latches", {62'b0, wel, rwel}, 64'b11);

        // R10 reads and foreign selects
        ev(0, 0); ev(2, 8'hDF); ev(2, 8'h3F); ev(2, 8'h00); ev(1, 0);
        chk("R10 read latches", {62'b0, wel, rwel}, 64'b11);
        ev(0, 0); ev(2, 8'hA0); ev(2, 8'h00); ev(2, 8'h99); ev(1, 0);
        chk("R10 foreign bank", regs, mdl);

        // R9 undefined start address
        burst(8'h20, 2, 8'h60);
        chk("R9 undefined bank", regs, mdl);
        chk("R9 undefined busy", {63'b0, busy}, 64'd0);

        // R9 partial burst past the end
        burst(8'h06, 4, 8'hC0);
        t0 = cyc;
        mdl[48 +: 8] = 8'hC0; mdl[56 +: 8] = 8'hC1;
        chk("R9 partial bank", regs, mdl);

        // R11 burst during busy
        burst(8'h00, 1, 8'h77);
        chk("R11 bank", regs, mdl);
        chk("R11 still busy", {63'b0, busy}, 64'd1);
        while (busy) @(negedge clk);
        chk("R11 no restart", 64'(cyc - t0), 64'(CCYC));

        // R12 status frame with two data bytes
        ev(0, 0); ev(2, 8'hDE); ev(2, 8'h3F); ev(2, 8'h00); ev(2, 8'h00); ev(1, 0);
        chk("R12 latches", {62'b0, wel, rwel}, 64'b10);
        stat_write(8'h06);
        ev(0, 0); ev(2, 8'hDE); ev(2, 8'h3F); ev(2, 8'h00); ev(3, 0); ev(1, 0);
        chk("R12 malformed latches", {62'b0, wel, rwel}, 64'b11);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule